// File: doc/BRIEF.md
# Data-Link Interrupt Status Register

This block holds the sticky status flags raised by a receive deframer on a serial data-link channel, together with a per-flag interrupt enable register. It combines the two into a single level interrupt toward the processor. Three single-cycle event pulses feed it: a frame-check error at the end of a message, a received abort pattern, and a received idle-flag pattern that marks a message as one of a repeated series. Each pulse sets its own flag, and the flag stays set until software clears it.

Software reaches the block through a small synchronous register port with two registers: status and enable. A global mode input selects how status flags are cleared. In clear-on-read mode, a read of the status register clears every flag it returned. In write-one-to-clear mode, software writes a 1 to each flag it wants to drop, and reads have no side effect. The interrupt output is raised only while the block-level enable is high and at least one set flag has its per-flag enable set.

Top module: `dl_int_status`

## Requirements
- R1: After a synchronous reset, all status flags and all enable bits are 0 and `irq` is low.
- R2: An event pulse sets its status flag at the next clock edge. The status bit positions are: bit 2 for frame-check error, bit 1 for abort received, and bit 0 for idle-flag received.
- R3: A set status flag holds its value while no clear for that flag occurs.
- R4: When `clear_on_read` is 1, a read of the status register (`reg_addr` = 0) returns the current flags in that same cycle and clears all of them at the next edge.
- R5: When `clear_on_read` is 0, writing the status register clears each flag whose write-data bit is 1 and leaves the flags with a 0 bit unchanged. Reads of the status register clear nothing in this mode.
- R6: When `clear_on_read` is 1, writes to the status register have no effect on the flags.
- R7: An event that arrives in the same cycle as a clear of its flag wins, so the flag is 1 after the edge.
- R8: The enable register (`reg_addr` = 1) stores write-data bits 2..0, using the same bit positions as the status register, and bit 2 enables the frame-check error interrupt. Its upper read-data bits are always 0.
- R9: `irq` is high exactly when `blk_irq_en` is 1 and some status flag and its enable bit are both 1. It is a level signal that falls once the enabled flags are cleared.
- R10: A read of the enable register never clears any status flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_fcs_err | input | 1 | Single-cycle pulse: frame-check error detected |
| ev_abort | input | 1 | Single-cycle pulse: abort pattern received |
| ev_idle | input | 1 | Single-cycle pulse: idle-flag pattern received |
| clear_on_read | input | 1 | 1 selects clear-on-read, 0 selects write-one-to-clear |
| blk_irq_en | input | 1 | Block-level interrupt enable |
| reg_rd | input | 1 | Register read strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 selects status, 1 selects enable |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data (combinational, value before this cycle's clear) |
| irq | output | 1 | Level interrupt request |

## Verification
On every cycle, the assertions check the flag update rules: an event sets its flag, a flag holds when nothing touches it, and a clear-on-read or write-one-to-clear access clears the flags it should. They also check that `irq` never rises without the block enable and a matching enabled flag. The bench's scenarios are the only way to show that read data carries the value from before the clear, how the two modes behave when switched at runtime, that writes in clear-on-read mode and reads of the enable register leave the flags intact, and how `irq` falls when only some of the flags are cleared.

// File: rtl/dl_int_pkg.sv
package dl_int_pkg;

    localparam int NUM_FLAGS = 3;
    localparam int REG_W     = 8;

    typedef enum logic [0:0] {
        SEL_STATUS = 1'b0,
        SEL_ENABLE = 1'b1
    } dl_reg_sel_e;

    // Field order fixes the bit positions: fcs at 2, abort at 1, idle at 0.
    typedef struct packed {
        logic fcs_err;
        logic abort;
        logic idle;
    } dl_flags_t;

    typedef struct packed {
        logic                 rd;
        logic                 wr;
        dl_reg_sel_e          sel;
        logic [REG_W-1:0]     wdata;
    } dl_access_t;

    // Flags that an access asks to clear this cycle.
    function automatic logic [NUM_FLAGS-1:0] clear_mask(
        input logic       rd_mode,
        input dl_access_t acc
    );
        logic [NUM_FLAGS-1:0] m;
        m = '0;
        if (acc.sel == SEL_STATUS) begin
            if (rd_mode && acc.rd)
                m = '1;
            else if (!rd_mode && acc.wr)
                m = acc.wdata[NUM_FLAGS-1:0];
        end
        return m;
    endfunction

    function automatic logic [REG_W-1:0] widen(input logic [NUM_FLAGS-1:0] v);
        logic [REG_W-1:0] r;
        r = '0;
        r[NUM_FLAGS-1:0] = v;
        return r;
    endfunction

endpackage

// File: rtl/dl_flag_bank.sv
module dl_flag_bank #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] flag_o
);
    for (genvar i = 0; i < N; i++) begin : g_flag
        logic q;
        always_ff @(posedge clk) begin
            if (rst)
                q <= 1'b0;
            else if (set_i[i])
                q <= 1'b1;       // event wins over clear
            else if (clr_i[i])
                q <= 1'b0;
        end
        assign flag_o[i] = q;
    end
endmodule

// File: rtl/dl_enable_reg.sv
module dl_enable_reg #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load_i,
    input  logic [N-1:0] d_i,
    output logic [N-1:0] q_o
);
    always_ff @(posedge clk) begin
        if (rst)
            q_o <= '0;
        else if (load_i)
            q_o <= d_i;
    end
endmodule

// File: rtl/dl_irq_reduce.sv
module dl_irq_reduce #(
    parameter int N = 3
) (
    input  logic [N-1:0] flag_i,
    input  logic [N-1:0] en_i,
    input  logic         blk_en_i,
    output logic         irq_o
);
    assign irq_o = blk_en_i & (|(flag_i & en_i));
endmodule

// File: rtl/dl_int_status.sv
module dl_int_status
    import dl_int_pkg::*;
#(
    parameter int NUM_SRC = NUM_FLAGS,
    parameter int DATA_W  = REG_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ev_fcs_err,
    input  logic              ev_abort,
    input  logic              ev_idle,
    input  logic              clear_on_read,
    input  logic              blk_irq_en,
    input  logic              reg_rd,
    input  logic              reg_wr,
    input  logic              reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq
);
    dl_flags_t            events;
    dl_access_t           acc;
    logic [NUM_SRC-1:0]   clr_vec;
    logic [NUM_SRC-1:0]   stat_q;
    logic [NUM_SRC-1:0]   en_q;
    logic                 en_load;

    always_comb begin
        events.fcs_err = ev_fcs_err;
        events.abort   = ev_abort;
        events.idle    = ev_idle;
        acc.rd         = reg_rd;
        acc.wr         = reg_wr;
        acc.sel        = dl_reg_sel_e'(reg_addr);
        acc.wdata      = reg_wdata;
    end

    assign clr_vec = clear_mask(clear_on_read, acc);
    assign en_load = reg_wr && (acc.sel == SEL_ENABLE);

    dl_flag_bank #(.N(NUM_SRC)) u_flags (
        .clk    (clk),
        .rst    (rst),
        .set_i  (events),
        .clr_i  (clr_vec),
        .flag_o (stat_q)
    );

    dl_enable_reg #(.N(NUM_SRC)) u_enable (
        .clk    (clk),
        .rst    (rst),
        .load_i (en_load),
        .d_i    (reg_wdata[NUM_SRC-1:0]),
        .q_o    (en_q)
    );

    dl_irq_reduce #(.N(NUM_SRC)) u_irq (
        .flag_i   (stat_q),
        .en_i     (en_q),
        .blk_en_i (blk_irq_en),
        .irq_o    (irq)
    );

    always_comb begin
        unique case (acc.sel)
            SEL_STATUS: reg_rdata = widen(stat_q);
            SEL_ENABLE: reg_rdata = widen(en_q);
            default:    reg_rdata = '0;
        endcase
    end

    logic unused_hi;
    assign unused_hi = ^reg_wdata[DATA_W-1:NUM_SRC];

endmodule

// File: rtl/dl_int_status_chk.sv
module dl_int_status_chk #(
    parameter int N = 3
) (
    input logic         clk,
    input logic         rst,
    input logic [N-1:0] ev,
    input logic         mode_rd,
    input logic         blk_en,
    input logic         rd,
    input logic         wr,
    input logic         addr,
    input logic [N-1:0] wbits,
    input logic [N-1:0] stat,
    input logic [N-1:0] en,
    input logic         irq
);
    p_reset_r1: assert property (@(posedge clk)
        rst |=> (stat == '0) && (en == '0));

    p_evt_sets_r2: assert property (@(posedge clk) disable iff (rst)
        (ev != '0) |=> ((stat & $past(ev)) == $past(ev)));

    p_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (ev == '0) && !((rd || wr) && !addr) |=> (stat == $past(stat)));

    p_rd_clear_r4: assert property (@(posedge clk) disable iff (rst)
        mode_rd && rd && !addr && (ev == '0) |=> (stat == '0));

    p_wr_clear_r5: assert property (@(posedge clk) disable iff (rst)
        !mode_rd && wr && !addr && (ev == '0) |=> (stat == ($past(stat) & ~$past(wbits))));

    p_evt_wins_r7: assert property (@(posedge clk) disable iff (rst)
        (rd || wr) && !addr && (ev != '0) |=> ((stat & $past(ev)) == $past(ev)));

    p_irq_gate_r9: assert property (@(posedge clk) disable iff (rst)
        irq |-> (blk_en && ((stat & en) != '0)));

    p_irq_off_r9: assert property (@(posedge clk) disable iff (rst)
        !blk_en |-> !irq);
endmodule

bind dl_int_status dl_int_status_chk #(.N(NUM_SRC)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .ev      (events),
    .mode_rd (clear_on_read),
    .blk_en  (blk_irq_en),
    .rd      (reg_rd),
    .wr      (reg_wr),
    .addr    (reg_addr),
    .wbits   (reg_wdata[NUM_SRC-1:0]),
    .stat    (stat_q),
    .en      (en_q),
    .irq     (irq)
);

// File: tb/dl_int_status_bench.sv
module dl_int_status_bench;
    logic       clk = 1'b0;
    logic       rst;
    logic       ev_fcs_err, ev_abort, ev_idle;
    logic       clear_on_read, blk_irq_en;
    logic       reg_rd, reg_wr, reg_addr;
    logic [7:0] reg_wdata;
    logic [7:0] reg_rdata;
    logic       irq;

    int n_checks = 0;
    int n_fail   = 0;

    always #5 clk = ~clk;

    dl_int_status u_dl_int_status (
        .clk(clk), .rst(rst),
        .ev_fcs_err(ev_fcs_err), .ev_abort(ev_abort), .ev_idle(ev_idle),
        .clear_on_read(clear_on_read), .blk_irq_en(blk_irq_en),
        .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    // Events: bit2 fcs, bit1 abort, bit0 idle
    task automatic pulse(input logic [2:0] e);
        {ev_fcs_err, ev_abort, ev_idle} = e;
        step();
        {ev_fcs_err, ev_abort, ev_idle} = 3'b000;
    endtask

    task automatic wr_reg(input logic a, input logic [7:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        step();
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    // Reads the status in write-clear mode, so nothing is cleared.
    task automatic peek(input string tag, input logic [7:0] exp);
        logic saved;
        saved = clear_on_read;
        clear_on_read = 1'b0; reg_rd = 1'b1; reg_addr = 1'b0;
        #1;
        check(tag, reg_rdata, exp);
        step();
        reg_rd = 1'b0; clear_on_read = saved;
    endtask

    task automatic rd_reg(input string tag, input logic a, input logic [7:0] exp);
        reg_rd = 1'b1; reg_addr = a;
        #1;
        check(tag, reg_rdata, exp);
        step();
        reg_rd = 1'b0;
    endtask

    task automatic t_reset();
        #1;
        check("R1 irq after reset", {7'b0, irq}, 8'h00);
        peek("R1 status after reset", 8'h00);
        rd_reg("R1 enable after reset", 1'b1, 8'h00);
    endtask

    task automatic t_set_hold();
        clear_on_read = 1'b0;
        pulse(3'b001); peek("R2 idle sets bit0", 8'h01);
        pulse(3'b100); peek("R2 fcs sets bit2", 8'h05);
        pulse(3'b010); peek("R2 abort sets bit1", 8'h07);
        repeat (4) step();
        peek("R3 flags hold", 8'h07);
    endtask

    task automatic t_read_clear();
        clear_on_read = 1'b1;
        rd_reg("R4 read returns pre-clear value", 1'b0, 8'h07);
        peek("R4 read cleared flags", 8'h00);
    endtask

    task automatic t_write_clear();
        clear_on_read = 1'b0;
        pulse(3'b111);
        wr_reg(1'b0, 8'h02);
        peek("R5 write-1 clears only bit1", 8'h05);
        rd_reg("R5 read in write-clear mode", 1'b0, 8'h05);
        peek("R5 read did not clear", 8'h05);
        wr_reg(1'b0, 8'h05);
        peek("R5 remaining flags cleared", 8'h00);
    endtask

    task automatic t_write_ignored();
        clear_on_read = 1'b1;
        pulse(3'b111);
        wr_reg(1'b0, 8'h07);
        peek("R6 write ignored in read-clear mode", 8'h07);
        rd_reg("R6 drain", 1'b0, 8'h07);
    endtask

    task automatic t_event_wins();
        clear_on_read = 1'b1;
        pulse(3'b010);
        reg_rd = 1'b1; reg_addr = 1'b0; ev_fcs_err = 1'b1;
        step();
        reg_rd = 1'b0; ev_fcs_err = 1'b0;
        peek("R7 event beats read-clear", 8'h04);
        clear_on_read = 1'b0;
        reg_wr = 1'b1; reg_addr = 1'b0; reg_wdata = 8'h04; ev_fcs_err = 1'b1;
        step();
        reg_wr = 1'b0; reg_wdata = '0; ev_fcs_err = 1'b0;
        peek("R7 event beats write-clear", 8'h04);
        wr_reg(1'b0, 8'h07);
    endtask

    task automatic t_enable();
        wr_reg(1'b1, 8'hFF);
        rd_reg("R8 enable upper bits read zero", 1'b1, 8'h07);
        wr_reg(1'b1, 8'h04);
        rd_reg("R8 enable bit2 stored", 1'b1, 8'h04);
    endtask

    task automatic t_irq();
        clear_on_read = 1'b0; blk_irq_en = 1'b1;
        pulse(3'b010); #1;
        check("R9 masked flag gives no irq", {7'b0, irq}, 8'h00);
        pulse(3'b100); #1;
        check("R9 enabled fcs raises irq", {7'b0, irq}, 8'h01);
        blk_irq_en = 1'b0; #1;
        check("R9 block enable gates irq", {7'b0, irq}, 8'h00);
        blk_irq_en = 1'b1; #1;
        check("R9 irq returns with block enable", {7'b0, irq}, 8'h01);
        wr_reg(1'b0, 8'h04); #1;
        check("R9 irq drops after clear", {7'b0, irq}, 8'h00);
        peek("R9 abort still set", 8'h02);
        wr_reg(1'b0, 8'h02);
    endtask

    task automatic t_enable_read_no_clear();
        clear_on_read = 1'b1;
        pulse(3'b101);
        rd_reg("R10 enable read", 1'b1, 8'h04);
        peek("R10 status untouched by enable read", 8'h05);
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        #2_000_000;
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        rst = 1'b1;
        {ev_fcs_err, ev_abort, ev_idle} = 3'b000;
        clear_on_read = 1'b0; blk_irq_en = 1'b0;
        reg_rd = 1'b0; reg_wr = 1'b0; reg_addr = 1'b0; reg_wdata = '0;
        repeat (3) step();
        rst = 1'b0;
        t_reset();
        t_set_hold();
        t_read_clear();
        t_write_clear();
        t_write_ignored();
        t_event_wins();
        t_enable();
        t_irq();
        t_enable_read_no_clear();
        finish_run();
    end
endmodule